// File: doc/BRIEF.md
# Internal Data Space Operand Resolver

This block sits between a small 8-bit controller's instruction decoder and its internal data storage. It takes one operand specifier per request and turns it into a physical access. The specifier is a register number, a direct byte address, or an indirect reference through a pointer register. For each request it drives a target select (internal RAM or special-function-register space), an 8-bit physical address and a read or write strobe. The block also holds the two-bit register-bank selector.

A register operand is moved into the active bank's eight-byte window. A direct address in the lower half of the map goes to RAM, and one in the upper half goes to the SFR space. An indirect operand first reads the pointer register from the active bank. That costs one cycle, marked by `busy`. The block then issues the access at the pointer value, and this always lands in RAM, including upper RAM at 80H and above. Direct accesses to SFR addresses that do not exist are suppressed and reported. Pointer references through registers other than the first two are refused.

Top module: `data_operand_resolver`

## Requirements
- R1: After reset the bank selector is 0, `busy` is low, and no strobe, `acc_done`, `acc_illegal` or `sfr_err` is active.
- R2: A register operand (kind 0) with index n, accepted at a clock edge, gives in the following cycle a RAM access (`mem_to_sfr`=0) at address bank*8+n with `mem_rd`=!we and `mem_wr`=we. This holds for every bank 0 to 3.
- R3: A direct operand (kind 1) below 80H gives, one cycle after acceptance, a RAM access at that same address. So direct address bank*8+n reaches the same byte as register n in bank `bank`.
- R4: A direct operand at 80H or above that names an existing SFR gives an SFR access (`mem_to_sfr`=1) at that address, and `rdata` returns the SFR read data. The accumulator is at E0H and the B register at F0H.
- R5: A direct operand at a non-existent SFR address raises `sfr_err` for exactly one cycle, asserts neither strobe, and drives `rdata` to 00H.
- R6: An indirect operand (kind 2) through index 0 or 1 first spends one cycle with `busy` high, reading RAM at bank*8+index. The next cycle issues the access in RAM at the byte read, with `acc_done` high. This applies also when the pointer is 80H or above.
- R7: An indirect operand through index 2 to 7, or a request of kind 3, raises `acc_illegal` with `acc_done` for one cycle, with no strobe and no pointer fetch.
- R8: A bank write (`bank_wr`) takes effect from the next clock edge. A request accepted at that same edge, or already in its pointer fetch, uses the bank it started with.
- R9: A request presented while `busy` is high is ignored and produces no access.
- R10: `acc_done` is a single-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 register, 1 direct, 2 indirect, 3 reserved |
| req_reg | input | 3 | Register index / pointer register index |
| req_addr | input | 8 | Direct address |
| req_we | input | 1 | 1 write, 0 read |
| bank_wr | input | 1 | Load bank selector |
| bank_wdata | input | 2 | New bank value |
| ram_rdata | input | 8 | RAM read data for the current address |
| sfr_rdata | input | 8 | SFR read data for the current address |
| busy | output | 1 | Pointer fetch in progress |
| cur_bank | output | 2 | Active bank selector |
| mem_to_sfr | output | 1 | 1 selects SFR space, 0 RAM |
| mem_addr | output | 8 | Physical address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| rdata | output | 8 | Returned read data |
| acc_done | output | 1 | Request completed this cycle |
| acc_illegal | output | 1 | Illegal pointer request |
| sfr_err | output | 1 | Access to non-existent SFR |

## Verification
The bench builds the block with its defaults: four banks of eight registers. With these values every bank window from 00H to 1FH can be reached, and each window can be checked against direct addresses and the alias byte. Pointer values on both sides of 80H are used, to show that indirect accesses never leave RAM. Bank writes are timed to land on the accepting edge and inside a pointer fetch, and requests are driven into the busy cycle, to exercise the ordering rules.

// File: rtl/dor_pkg.sv
package dor_pkg;
  localparam int ADDR_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    OP_REG = 2'd0,
    OP_DIR = 2'd1,
    OP_IND = 2'd2,
    OP_RSV = 2'd3
  } op_kind_e;

  typedef struct packed {
    logic  to_sfr;
    addr_t addr;
    logic  legal;
    logic  fetch;
    logic  missing;
  } route_t;

  // RAM byte holding register idx of a bank
  function automatic addr_t bank_slot(input int unsigned bank,
                                      input int unsigned idx,
                                      input int unsigned nreg);
    return addr_t'(bank * nreg + idx);
  endfunction

  // SFR addresses that exist in this controller
  function automatic logic sfr_present(input addr_t a);
    case (a)
      8'h80, 8'h81, 8'h82, 8'h83, 8'h87, 8'h88, 8'h89, 8'h8A,
      8'h8B, 8'h8C, 8'h8D, 8'h90, 8'h98, 8'h99, 8'hA0, 8'hA8,
      8'hB0, 8'hB8, 8'hC8, 8'hC9, 8'hCA, 8'hCB, 8'hCC, 8'hCD,
      8'hD0, 8'hE0, 8'hF0: return 1'b1;
      default:             return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dor_bank.sv
module dor_bank #(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_val,
  output logic [BANK_W-1:0] bank
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bank <= '0;
    else if (wr_en) bank <= wr_val;
  end
endmodule

// File: rtl/dor_decode.sv
module dor_decode
  import dor_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int NREG   = 8,
  parameter int BANK_W = $clog2(NBANK),
  parameter int REG_W  = $clog2(NREG)
) (
  input  op_kind_e          kind,
  input  logic [REG_W-1:0]  reg_idx,
  input  addr_t             dir_addr,
  input  logic [BANK_W-1:0] bank,
  output route_t            route,
  output addr_t             ptr_slot
);
  addr_t slot;

  always_comb begin
    slot     = bank_slot(32'(bank), 32'(reg_idx), NREG);
    ptr_slot = slot;
    route    = '0;
    unique case (kind)
      OP_REG: begin
        route.legal = 1'b1;
        route.addr  = slot;
      end
      OP_DIR: begin
        route.legal   = 1'b1;
        route.to_sfr  = dir_addr[ADDR_W-1];
        route.addr    = dir_addr;
        route.missing = dir_addr[ADDR_W-1] && !sfr_present(dir_addr);
      end
      OP_IND: begin
        route.legal = (reg_idx <= REG_W'(1));
        route.fetch = route.legal;
      end
      default: route.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/data_operand_resolver.sv
module data_operand_resolver
  import dor_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int NREG  = 8,
  localparam int BANK_W = $clog2(NBANK),
  localparam int REG_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [7:0]        req_addr,
  input  logic              req_we,
  input  logic              bank_wr,
  input  logic [BANK_W-1:0] bank_wdata,
  input  logic [7:0]        ram_rdata,
  input  logic [7:0]        sfr_rdata,
  output logic              busy,
  output logic [BANK_W-1:0] cur_bank,
  output logic              mem_to_sfr,
  output logic [7:0]        mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [7:0]        rdata,
  output logic              acc_done,
  output logic              acc_illegal,
  output logic              sfr_err
);
  typedef enum logic {ST_IDLE, ST_FETCH} state_e;

  state_e st_q;
  route_t route;
  addr_t  ptr_slot;
  logic   pend_we_q;
  logic   zero_q;

  // named events
  logic accept, fetch_start, ind_issue;
  assign busy        = (st_q == ST_FETCH);
  assign accept      = req_valid && !busy;
  assign fetch_start = accept && route.fetch;
  assign ind_issue   = busy;

  dor_bank #(.BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(bank_wr), .wr_val(bank_wdata), .bank(cur_bank)
  );

  dor_decode #(.NBANK(NBANK), .NREG(NREG)) u_decode (
    .kind(op_kind_e'(req_kind)), .reg_idx(req_reg), .dir_addr(req_addr),
    .bank(cur_bank), .route(route), .ptr_slot(ptr_slot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      pend_we_q   <= 1'b0;
      zero_q      <= 1'b0;
      mem_to_sfr  <= 1'b0;
      mem_addr    <= '0;
      mem_rd      <= 1'b0;
      mem_wr      <= 1'b0;
      acc_done    <= 1'b0;
      acc_illegal <= 1'b0;
      sfr_err     <= 1'b0;
    end else begin
      mem_rd      <= 1'b0;
      mem_wr      <= 1'b0;
      acc_done    <= 1'b0;
      acc_illegal <= 1'b0;
      sfr_err     <= 1'b0;
      zero_q      <= 1'b0;
      if (ind_issue) begin
        st_q       <= ST_IDLE;
        mem_to_sfr <= 1'b0;
        mem_addr   <= ram_rdata;
        mem_rd     <= !pend_we_q;
        mem_wr     <= pend_we_q;
        acc_done   <= 1'b1;
      end else if (fetch_start) begin
        st_q       <= ST_FETCH;
        pend_we_q  <= req_we;
        mem_to_sfr <= 1'b0;
        mem_addr   <= ptr_slot;
        mem_rd     <= 1'b1;
      end else if (accept) begin
        acc_done <= 1'b1;
        if (!route.legal) begin
          acc_illegal <= 1'b1;
        end else begin
          mem_to_sfr <= route.to_sfr;
          mem_addr   <= route.addr;
          if (route.missing) begin
            sfr_err <= 1'b1;
            zero_q  <= 1'b1;
          end else begin
            mem_rd <= !req_we;
            mem_wr <= req_we;
          end
        end
      end
    end
  end

  assign rdata = zero_q ? 8'h00 : (mem_to_sfr ? sfr_rdata : ram_rdata);
endmodule

// File: rtl/data_operand_resolver_chk.sv
module data_operand_resolver_chk #(
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              bank_wr,
  input logic [BANK_W-1:0] cur_bank,
  input logic              mem_to_sfr,
  input logic [7:0]        mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [7:0]        rdata,
  input logic              acc_done,
  input logic              acc_illegal,
  input logic              sfr_err
);
  // pointer fetch reads a low RAM register slot
  p_fetch_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mem_rd && !mem_wr && !mem_to_sfr && mem_addr < 8'h20));

  // fetch lasts one cycle and is followed by completion
  p_fetch_then_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy && acc_done && !mem_to_sfr));

  p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_illegal |-> (!mem_rd && !mem_wr && acc_done));

  p_missing_sfr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_err |-> (!mem_rd && !mem_wr && rdata == 8'h00 && mem_to_sfr));

  p_sfr_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && mem_to_sfr) |-> mem_addr[7]);

  p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_wr |=> $stable(cur_bank));

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr) && !(acc_done && busy));
endmodule

bind data_operand_resolver data_operand_resolver_chk #(.BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .bank_wr(bank_wr), .cur_bank(cur_bank),
  .mem_to_sfr(mem_to_sfr), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .rdata(rdata), .acc_done(acc_done), .acc_illegal(acc_illegal), .sfr_err(sfr_err)
);

// File: tb/test_data_operand_resolver.sv
module test_data_operand_resolver;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [2:0] req_reg = 3'd0;
  logic [7:0] req_addr = 8'd0;
  logic req_we = 1'b0;
  logic bank_wr = 1'b0;
  logic [1:0] bank_wdata = 2'd0;
  logic [7:0] ram_rdata, sfr_rdata;
  logic busy, mem_to_sfr, mem_rd, mem_wr, acc_done, acc_illegal, sfr_err;
  logic [1:0] cur_bank;
  logic [7:0] mem_addr, rdata;

  logic [7:0] ram [256];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign ram_rdata = ram[mem_addr];
  assign sfr_rdata = ~mem_addr;

  data_operand_resolver i_data_operand_resolver (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_reg(req_reg), .req_addr(req_addr), .req_we(req_we), .bank_wr(bank_wr),
    .bank_wdata(bank_wdata), .ram_rdata(ram_rdata), .sfr_rdata(sfr_rdata),
    .busy(busy), .cur_bank(cur_bank), .mem_to_sfr(mem_to_sfr), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .rdata(rdata), .acc_done(acc_done),
    .acc_illegal(acc_illegal), .sfr_err(sfr_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // present a request for one edge; outputs are then checked at this negedge
  task automatic issue(input logic [1:0] k, input logic [2:0] r, input logic [7:0] a, input logic w);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_reg = r; req_addr = a; req_we = w;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_bank(input logic [1:0] b);
    @(negedge clk);
    bank_wr = 1'b1; bank_wdata = b;
    @(negedge clk);
    bank_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 bank", cur_bank, 0);
    chk("R1 busy", busy, 0);
    chk("R1 strobes", {mem_rd, mem_wr, acc_done, acc_illegal, sfr_err}, 0);
  endtask

  task automatic t_register();
    for (int b = 0; b < 4; b++) begin
      set_bank(2'(b));
      issue(2'd0, 3'd5, 8'h00, 1'b0);
      chk("R2 addr", mem_addr, 32'(b * 8 + 5));
      chk("R2 sel/rd/wr/done", {mem_to_sfr, mem_rd, mem_wr, acc_done}, 4'b0101);
      @(negedge clk);
      chk("R10 done pulse", {acc_done, mem_rd}, 0);
    end
    issue(2'd0, 3'd7, 8'h00, 1'b1);
    chk("R2 write bank3 R7", {mem_addr, mem_rd, mem_wr}, {8'h1F, 2'b01});
  endtask

  task automatic t_direct_low();
    issue(2'd1, 3'd0, 8'h45, 1'b1);
    chk("R3 direct ram", {mem_to_sfr, mem_addr, mem_wr}, {1'b0, 8'h45, 1'b1});
    set_bank(2'd1);
    issue(2'd1, 3'd0, 8'h0D, 1'b0);
    chk("R3 alias direct", {mem_to_sfr, mem_addr, rdata}, {1'b0, 8'h0D, ram[8'h0D]});
    issue(2'd0, 3'd5, 8'h00, 1'b0);
    chk("R3 alias register", {mem_addr, rdata}, {8'h0D, ram[8'h0D]});
  endtask

  task automatic t_direct_sfr();
    issue(2'd1, 3'd0, 8'hE0, 1'b0);
    chk("R4 accumulator", {mem_to_sfr, mem_addr, mem_rd, rdata}, {1'b1, 8'hE0, 1'b1, 8'h1F});
    issue(2'd1, 3'd0, 8'hF0, 1'b1);
    chk("R4 B reg", {mem_to_sfr, mem_addr, mem_wr, sfr_err}, {1'b1, 8'hF0, 1'b1, 1'b0});
    issue(2'd1, 3'd0, 8'h80, 1'b0);
    chk("R4 boundary 80", {mem_to_sfr, mem_addr, mem_rd}, {1'b1, 8'h80, 1'b1});
    issue(2'd1, 3'd0, 8'h7F, 1'b0);
    chk("R3 boundary 7F", {mem_to_sfr, mem_addr}, {1'b0, 8'h7F});
  endtask

  task automatic t_missing_sfr();
    issue(2'd1, 3'd0, 8'h84, 1'b0);
    chk("R5 missing read", {sfr_err, mem_rd, mem_wr, rdata, acc_done}, {3'b100, 8'h00, 1'b1});
    @(negedge clk);
    chk("R5 err one cycle", sfr_err, 0);
    issue(2'd1, 3'd0, 8'hFF, 1'b1);
    chk("R5 missing write", {sfr_err, mem_wr}, 2'b10);
  endtask

  task automatic t_indirect();
    set_bank(2'd2);
    issue(2'd2, 3'd1, 8'h00, 1'b1);
    chk("R6 fetch", {busy, mem_rd, mem_wr, mem_to_sfr, mem_addr}, {4'b1100, 8'h11});
    chk("R6 no done in fetch", acc_done, 0);
    @(negedge clk);
    chk("R6 upper ram write", {busy, mem_to_sfr, mem_addr, mem_wr, acc_done}, {2'b00, 8'hA5, 2'b11});
    issue(2'd2, 3'd0, 8'h00, 1'b0);
    chk("R6 fetch R0", {busy, mem_addr}, {1'b1, 8'h10});
    @(negedge clk);
    chk("R6 low ram read", {mem_to_sfr, mem_addr, mem_rd, rdata}, {1'b0, 8'h33, 1'b1, ram[8'h33]});
  endtask

  task automatic t_illegal();
    issue(2'd2, 3'd3, 8'h00, 1'b0);
    chk("R7 illegal ptr", {acc_illegal, acc_done, busy, mem_rd, mem_wr}, 5'b11000);
    @(negedge clk);
    chk("R7 one cycle", {acc_illegal, busy}, 0);
    issue(2'd3, 3'd0, 8'h40, 1'b1);
    chk("R7 reserved kind", {acc_illegal, mem_wr}, 2'b10);
  endtask

  task automatic t_bank_order();
    set_bank(2'd0);
    @(negedge clk);
    bank_wr = 1'b1; bank_wdata = 2'd3;
    req_valid = 1'b1; req_kind = 2'd0; req_reg = 3'd2; req_we = 1'b0;
    @(negedge clk);
    bank_wr = 1'b0; req_valid = 1'b0;
    chk("R8 same-edge old bank", mem_addr, 8'h02);
    chk("R8 bank updated", cur_bank, 3);
    issue(2'd0, 3'd2, 8'h00, 1'b0);
    chk("R8 next request new bank", mem_addr, 8'h1A);
    set_bank(2'd0);
    issue(2'd2, 3'd0, 8'h00, 1'b0);
    bank_wr = 1'b1; bank_wdata = 2'd3;
    chk("R8 fetch bank0", mem_addr, 8'h00);
    @(negedge clk);
    bank_wr = 1'b0;
    chk("R8 pointer from old bank", mem_addr, 8'h77);
  endtask

  task automatic t_busy_ignore();
    set_bank(2'd0);
    issue(2'd2, 3'd0, 8'h00, 1'b0);
    chk("R9 busy", busy, 1);
    req_valid = 1'b1; req_kind = 2'd1; req_addr = 8'h50; req_we = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 issue unaffected", {mem_addr, mem_rd, mem_wr}, {8'h77, 2'b10});
    @(negedge clk);
    chk("R9 request dropped", {acc_done, mem_rd, mem_wr}, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'(i ^ 8'h5A);
    ram[8'h11] = 8'hA5;
    ram[8'h10] = 8'h33;
    ram[8'h00] = 8'h77;
    ram[8'h18] = 8'h99;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_register();
    t_direct_low();
    t_direct_sfr();
    t_missing_sfr();
    t_indirect();
    t_illegal();
    t_bank_order();
    t_busy_ignore();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule